// File: doc/BRIEF.md
# Execute-Stage Branch Resolver and Next-PC Selector

This block sits in the execute stage of a five-stage in-order pipeline. It takes a branch that has reached execute, computes where the branch would go, and decides from the ALU flags whether it goes there. It registers the result as the next program counter and as a one-cycle taken pulse. The fetch side loads the PC from that value, and the hazard logic uses the pulse to squash younger instructions.

Two conditional branch kinds are resolved. The first is branch-if-equal. The second is branch-if-rs-non-negative. Both use the ALU in subtract mode. For the non-negative branch, the block forces the ALU's second operand to zero, so the subtract result is rs itself. The ALU's zero and greater-than-zero flags then describe the sign of rs directly.

Top module: `bru_next_pc`

## Requirements
- R1: While rst_ni is low and at the first edge after it rises, taken_o is 0 and next_pc_o equals the parameter RESET_PC (default 0).
- R2: The branch target is pc_plus4_i + (imm_ext_i shifted left by 2), computed in 32 bits with wraparound; a taken branch presents it on next_pc_o.
- R3: With ex_valid_i=1, branch_i=1 and opcode_i=6'b000100 (equal), the branch is taken exactly when zero_i is 1.
- R4: With ex_valid_i=1, branch_i=1 and opcode_i=6'b000001 (non-negative), the branch is taken when zero_i or gtz_i is 1, and not taken when both are 0.
- R5: With branch_i=1 and any opcode other than the two above, the branch is never taken and next_pc_o becomes pc_plus4_i, whatever the flags.
- R6: With ex_valid_i=1 and branch_i=0, taken_o becomes 0 and next_pc_o becomes pc_plus4_i, whatever the opcode and flags.
- R7: In the same cycle, alu_b_o is 0 when branch_i=1 and opcode_i=6'b000001, and equals rt_data_i otherwise.
- R8: Inputs sampled at a rising edge with ex_valid_i=1 appear on taken_o and next_pc_o after that edge. A cycle sampled with ex_valid_i=0 gives taken_o=0 and leaves next_pc_o unchanged, so each valid taken branch yields a single-cycle pulse.
- R9: When pc_plus4_i is word aligned, next_pc_o is word aligned (bits 1:0 are 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ex_valid_i | input | 1 | A valid instruction occupies execute |
| branch_i | input | 1 | Branch control bit from decode |
| opcode_i | input | 6 | Primary opcode of the instruction in execute |
| pc_plus4_i | input | 32 | Address of the instruction after the branch |
| imm_ext_i | input | 32 | Sign-extended 16-bit word offset |
| rt_data_i | input | 32 | Second register operand after forwarding |
| zero_i | input | 1 | ALU result equals zero |
| gtz_i | input | 1 | ALU result is greater than zero (signed) |
| alu_b_o | output | 32 | Second ALU operand after the non-negative rule |
| taken_o | output | 1 | Registered branch-taken pulse |
| next_pc_o | output | 32 | Registered next program counter |

## Verification
The combinational operand rule and the registered resolution of the previous branch act in the same cycle. This happens when two branches arrive back to back: a non-negative branch enters execute while the branch-if-equal before it is being presented on taken_o and next_pc_o. The bench drives such pairs in consecutive cycles. It checks alu_b_o against zero within the cycle of entry, and the scoreboard compares the earlier branch's target and pulse one edge later. A mix-up between the two shows up as a wrong operand or as a result shifted by one cycle.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int unsigned OPC_W = 6;
  localparam logic [OPC_W-1:0] OPC_BR_EQ  = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_BR_GEZ = 6'b000001;

  typedef enum logic [1:0] {
    BR_NONE = 2'd0,
    BR_EQ   = 2'd1,
    BR_GEZ  = 2'd2
  } br_kind_e;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic             branch_i,
  input  logic [OPC_W-1:0] opcode_i,
  output br_kind_e         kind_o
);
  always_comb begin
    kind_o = BR_NONE;
    if (branch_i) begin
      unique case (opcode_i)
        OPC_BR_EQ:  kind_o = BR_EQ;
        OPC_BR_GEZ: kind_o = BR_GEZ;
        default:    kind_o = BR_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int unsigned AW    = 32,
  parameter int unsigned SHIFT = 2
) (
  input  logic [AW-1:0] pc_plus4_i,
  input  logic [AW-1:0] imm_ext_i,
  output logic [AW-1:0] target_o
);
  logic [AW-1:0] offset;
  assign offset   = {imm_ext_i[AW-1-SHIFT:0], {SHIFT{1'b0}}};
  assign target_o = pc_plus4_i + offset;
endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
(
  input  br_kind_e kind_i,
  input  logic     zero_i,
  input  logic     gtz_i,
  output logic     take_o
);
  always_comb begin
    unique case (kind_i)
      BR_EQ:   take_o = zero_i;
      BR_GEZ:  take_o = zero_i | gtz_i;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_opsel.sv
module bru_opsel
  import bru_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  br_kind_e      kind_i,
  input  logic [DW-1:0] rt_data_i,
  output logic [DW-1:0] alu_b_o
);
  // non-negative test: rs - 0 so the flags describe rs
  assign alu_b_o = (kind_i == BR_GEZ) ? '0 : rt_data_i;
endmodule

// File: rtl/bru_next_pc.sv
module bru_next_pc
  import bru_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   DW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ex_valid_i,
  input  logic          branch_i,
  input  logic [5:0]    opcode_i,
  input  logic [AW-1:0] pc_plus4_i,
  input  logic [AW-1:0] imm_ext_i,
  input  logic [DW-1:0] rt_data_i,
  input  logic          zero_i,
  input  logic          gtz_i,
  output logic [DW-1:0] alu_b_o,
  output logic          taken_o,
  output logic [AW-1:0] next_pc_o
);
  localparam int unsigned WORD_SHIFT = 2;

  br_kind_e      kind;
  logic          take;
  logic [AW-1:0] target;
  logic [AW-1:0] pc_sel;

  bru_decode u_decode (
    .branch_i (branch_i),
    .opcode_i (opcode_i),
    .kind_o   (kind)
  );

  bru_target #(.AW(AW), .SHIFT(WORD_SHIFT)) u_target (
    .pc_plus4_i (pc_plus4_i),
    .imm_ext_i  (imm_ext_i),
    .target_o   (target)
  );

  bru_cond u_cond (
    .kind_i (kind),
    .zero_i (zero_i),
    .gtz_i  (gtz_i),
    .take_o (take)
  );

  bru_opsel #(.DW(DW)) u_opsel (
    .kind_i    (kind),
    .rt_data_i (rt_data_i),
    .alu_b_o   (alu_b_o)
  );

  assign pc_sel = take ? target : pc_plus4_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o   <= 1'b0;
      next_pc_o <= RESET_PC;
    end else begin
      taken_o <= ex_valid_i & take;
      if (ex_valid_i) next_pc_o <= pc_sel;
    end
  end
endmodule

// File: rtl/bru_next_pc_chk.sv
module bru_next_pc_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ex_valid_i,
  input logic          branch_i,
  input logic [5:0]    opcode_i,
  input logic [AW-1:0] pc_plus4_i,
  input logic [AW-1:0] imm_ext_i,
  input logic          zero_i,
  input logic          gtz_i,
  input logic [DW-1:0] alu_b_o,
  input logic          taken_o,
  input logic [AW-1:0] next_pc_o
);
  AST_TAKEN_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> $past(ex_valid_i && branch_i)); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_valid_i |=> (!taken_o && $stable(next_pc_o))); // R8

  AST_NO_BRANCH_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_i && !branch_i) |=> (!taken_o && next_pc_o == $past(pc_plus4_i))); // R6

  AST_EQ_DECISION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_i && branch_i && opcode_i == 6'b000100) |=> (taken_o == $past(zero_i))); // R3

  AST_GEZ_DECISION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_i && branch_i && opcode_i == 6'b000001) |=> (taken_o == $past(zero_i || gtz_i))); // R4

  AST_OTHER_OPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_i && branch_i && opcode_i != 6'b000100 && opcode_i != 6'b000001)
      |=> (!taken_o && next_pc_o == $past(pc_plus4_i))); // R5

  AST_TAKEN_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (next_pc_o == $past(pc_plus4_i) + {$past(imm_ext_i[AW-3:0]), 2'b00})); // R2

  AST_GEZ_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_i && opcode_i == 6'b000001) |-> (alu_b_o == '0)); // R7

  AST_WORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_i && pc_plus4_i[1:0] == 2'b00) |=> (next_pc_o[1:0] == 2'b00)); // R9
endmodule

bind bru_next_pc bru_next_pc_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ex_valid_i (ex_valid_i),
  .branch_i   (branch_i),
  .opcode_i   (opcode_i),
  .pc_plus4_i (pc_plus4_i),
  .imm_ext_i  (imm_ext_i),
  .zero_i     (zero_i),
  .gtz_i      (gtz_i),
  .alu_b_o    (alu_b_o),
  .taken_o    (taken_o),
  .next_pc_o  (next_pc_o)
);

// File: tb/sim_bru_next_pc.sv
`timescale 1ns/1ps
module sim_bru_next_pc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ex_valid_i = 1'b0;
  logic        branch_i = 1'b0;
  logic [5:0]  opcode_i = '0;
  logic [31:0] pc_plus4_i = '0;
  logic [31:0] imm_ext_i = '0;
  logic [31:0] rt_data_i = '0;
  logic        zero_i = 1'b0;
  logic        gtz_i = 1'b0;
  logic [31:0] alu_b_o;
  logic        taken_o;
  logic [31:0] next_pc_o;

  always #2 clk_i = ~clk_i;

  bru_next_pc u0 (.*);

  typedef struct {
    logic        taken;
    logic [31:0] npc;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_checks = 0;
  int          n_errors = 0;
  logic [31:0] last_npc = 32'h0;
  bit          done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  // driver: applies one cycle of stimulus, pushes expected outcome
  task automatic drive(input bit v, input bit br, input logic [5:0] op, input logic [31:0] pc4,
                       input logic [31:0] imm, input logic [31:0] rt, input bit z, input bit g,
                       input string tag);
    exp_t        e;
    logic [31:0] tgt;
    logic [31:0] expb;
    bit          tk;
    @(negedge clk_i);
    ex_valid_i = v; branch_i = br; opcode_i = op; pc_plus4_i = pc4;
    imm_ext_i = imm; rt_data_i = rt; zero_i = z; gtz_i = g;
    tgt = pc4 + (imm << 2);
    tk  = br && ((op == 6'b000100 && z) || (op == 6'b000001 && (z || g)));
    if (v) begin
      e.taken = tk;
      e.npc   = tk ? tgt : pc4;
      last_npc = e.npc;
    end else begin
      e.taken = 1'b0;
      e.npc   = last_npc;
    end
    e.tag = tag;
    sb_q.push_back(e);
    #0.5;
    expb = (br && op == 6'b000001) ? 32'h0 : rt;
    check(alu_b_o == expb, "R7 operand", alu_b_o, expb);
  endtask

  // monitor: compares registered outputs just after each edge
  always @(posedge clk_i) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(taken_o == e.taken, {e.tag, " taken"}, {31'h0, taken_o}, {31'h0, e.taken});
      check(next_pc_o == e.npc, {e.tag, " next_pc"}, next_pc_o, e.npc);
      check(next_pc_o[1:0] == 2'b00, "R9 align", next_pc_o, e.npc);
    end
  end

  initial begin
    #100000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    #9;
    check(taken_o == 1'b0, "R1 taken in reset", {31'h0, taken_o}, 32'h0);
    check(next_pc_o == 32'h0, "R1 pc in reset", next_pc_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check(taken_o == 1'b0, "R1 taken after reset", {31'h0, taken_o}, 32'h0);
    check(next_pc_o == 32'h0, "R1 pc after reset", next_pc_o, 32'h0);

    drive(1, 1, 6'b000100, 32'h0000_0100, 32'h0000_0010, 32'h55, 1, 0, "R3 eq taken");
    drive(1, 1, 6'b000100, 32'h0000_0200, 32'h0000_0010, 32'h66, 0, 1, "R3 eq not taken");
    drive(1, 1, 6'b000001, 32'h0000_0300, 32'h0000_0004, 32'h77, 0, 1, "R4 gez positive");
    drive(1, 1, 6'b000001, 32'h0000_0400, 32'hFFFF_FFFC, 32'h88, 1, 0, "R4 gez zero");
    drive(1, 1, 6'b000001, 32'h0000_0500, 32'h0000_0008, 32'h99, 0, 0, "R4 gez negative");
    drive(1, 1, 6'b000100, 32'h0000_1000, 32'hFFFF_FF00, 32'h1, 1, 0, "R2 backward target");
    drive(1, 1, 6'b000100, 32'hFFFF_FFFC, 32'h0000_0002, 32'h2, 1, 0, "R2 wraparound");
    drive(1, 1, 6'b100011, 32'h0000_0600, 32'h0000_0040, 32'h3, 1, 1, "R5 other opcode");
    drive(1, 0, 6'b000100, 32'h0000_0700, 32'h0000_0040, 32'h4, 1, 1, "R6 no branch eq");
    drive(1, 0, 6'b000001, 32'h0000_0704, 32'h0000_0040, 32'h5, 1, 1, "R6 no branch gez");
    drive(0, 1, 6'b000100, 32'h0000_0800, 32'h0000_0040, 32'h6, 1, 0, "R8 idle branch");
    drive(0, 0, 6'b000000, 32'h0000_0900, 32'h0, 32'h7, 0, 0, "R8 idle hold");
    // back to back: operand rule of a new branch while the prior result is shown
    drive(1, 1, 6'b000100, 32'h0000_0A00, 32'h0000_0020, 32'h8, 1, 0, "R8 pair first");
    drive(1, 1, 6'b000001, 32'h0000_0A04, 32'h0000_0030, 32'h9, 0, 1, "R8 pair second");
    drive(1, 1, 6'b000001, 32'h0000_0A08, 32'h0000_0001, 32'hA, 0, 0, "R4 pair third");
    drive(0, 0, 6'b000000, 32'h0, 32'h0, 32'hB, 0, 0, "R8 pulse ends");
    for (int i = 0; i < 16; i++) begin
      logic [31:0] pc4;
      logic [31:0] imm;
      pc4 = 32'h0001_0000 + (i * 32'h44);
      imm = (i[0]) ? -(i * 3) : i * 5;
      drive(1, 1, (i[1] ? 6'b000001 : 6'b000100), pc4, imm, 32'h100 + i,
            i[2], i[3], "R2 sweep");
    end
    drive(0, 0, 6'b000000, 32'h0, 32'h0, 32'h0, 0, 0, "R8 drain");
    @(posedge clk_i); #2;
    finish_run();
  end
endmodule